// File: doc/BRIEF.md
# One's Complement Checksum Engine

This block keeps a running 16-bit one's complement sum over a stream of 16-bit words. A transmitter feeds it the words to be protected and places the complemented result into the outgoing frame. A receiver feeds it the same words followed by the received check word, and reads a pass flag once the sum has settled. Deciding which fields of a frame take part in the sum is left to the logic that drives the block.

Each word passes through a selector that yields the word when the enable input is high and zero when it is low. The selector output goes to a two's complement adder. The adder's carry-out is kept in a one-bit register, and that register feeds the adder's carry-in on the next cycle, so the end-around carry costs no extra adder stage. A compile-time option places a register between the selector and the adder, which cuts the path from the control inputs to the adder. With that option, clear, enable and data all pass through the same register, so they stay aligned. After the last word the driver holds enable low; any pending carry then drains on its own, and a done flag shows when the sum is final.

Top module: `csum_engine`

## Requirements
- R1: A cycle with `clr_i` high starts a new frame at the adder stage: the accumulator loads the selected operand and the carry register becomes 0. The operand is `data_i` when `en_i` is high and zero when `en_i` is low.
- R2: A cycle with `en_i` high and `clr_i` low adds `data_i` plus the stored carry to the accumulator and stores the new carry-out. Once the carries have drained, `sum_o` equals the folded one's complement sum of the frame's words. That folded sum is 0 only for an all-zero frame.
- R3: A cycle with `en_i` low and `clr_i` low adds only the stored carry, and `data_i` has no effect. When the carry is 0, `sum_o` stays unchanged.
- R4: `done_o` is high exactly when the carry register is 0 and no accepted clear or word is still waiting in the optional input register. While a carry is pending, `done_o` is low.
- R5: `chk_o` is always the bitwise complement of `sum_o`. For example, a frame holding only 0x8DC8 gives `chk_o` = 0x7237.
- R6: `pass_o` is high exactly when `done_o` is high and `sum_o` is 0x0000 or 0xFFFF.
- R7: With `PIPE` = 1, every effect of `clr_i`, `en_i` and `data_i` on `sum_o` appears exactly one cycle later than with `PIPE` = 0.
- R8: After a synchronous reset (`rst` high), `sum_o` = 0, `chk_o` = all ones, `done_o` = 1 and `pass_o` = 1.
- R9: A frame whose last word is the complement of the folded sum of the words before it ends with `pass_o` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Start of frame: load the operand instead of adding it |
| en_i | input | 1 | Sum enable: select `data_i` (1) or zero (0) |
| data_i | input | W | Word to be summed |
| sum_o | output | W | Running one's complement sum |
| chk_o | output | W | Complement of the sum, for insertion into a frame |
| done_o | output | 1 | No carry and no word pending; the sum is final |
| pass_o | output | 1 | Sum settled at 0x0000 or 0xFFFF |

## Verification
If the carry register is lost or stuck, the fault shows in `sum_o` at the end of any frame whose words overflow 16 bits. It also shows as `done_o` rising one cycle too early or never rising after two 0xFFFF words. A misaligned input register puts the clear or the first word of a frame into the wrong cycle. That shows in the cycle right after the clear, when a fresh frame's first word should appear in the sum. A mixing error in the adder corrupts the sum of a random frame. It also drops `pass_o` on the matching verify frame as soon as the carry has drained, which is within two cycles of the last word.

// File: rtl/csum_pkg.sv
package csum_pkg;

    // Default word width of the engine.
    localparam int CSUM_W = 16;

    // Control bits that travel with an operand towards the adder.
    typedef struct packed {
        logic clr;  // frame start: load instead of accumulate
        logic en;   // operand carries a real word
    } csum_ctl_t;

    // Control value of an idle cycle.
    function automatic csum_ctl_t ctl_idle();
        csum_ctl_t c;
        c.clr = 1'b0;
        c.en  = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/csum_in_stage.sv
module csum_in_stage
    import csum_pkg::*;
#(
    parameter int W    = CSUM_W,
    parameter bit PIPE = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic [W-1:0] data_i,
    output csum_ctl_t    ctl_o,
    output logic [W-1:0] opnd_o
);

    csum_ctl_t    ctl_in;
    logic [W-1:0] opnd_sel;

    // Operand selector: the word or a constant zero.
    always_comb begin
        ctl_in.clr = clr_i;
        ctl_in.en  = en_i;
        opnd_sel   = en_i ? data_i : '0;
    end

    generate
        if (PIPE) begin : g_reg
            csum_ctl_t    ctl_q;
            logic [W-1:0] opnd_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    ctl_q  <= ctl_idle();
                    opnd_q <= '0;
                end else begin
                    ctl_q  <= ctl_in;
                    opnd_q <= opnd_sel;
                end
            end

            assign ctl_o  = ctl_q;
            assign opnd_o = opnd_q;
        end else begin : g_thru
            assign ctl_o  = ctl_in;
            assign opnd_o = opnd_sel;
        end
    endgenerate

endmodule

// File: rtl/csum_accum.sv
module csum_accum
    import csum_pkg::*;
#(
    parameter int W = CSUM_W
) (
    input  logic         clk,
    input  logic         rst,
    input  csum_ctl_t    ctl_i,
    input  logic [W-1:0] opnd_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o
);

    logic [W-1:0] acc_q;
    logic         cy_q;
    logic [W:0]   total;

    // Two's complement adder; carry-in comes from last cycle's carry-out.
    assign total = {1'b0, acc_q} + {1'b0, opnd_i} + {{W{1'b0}}, cy_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            cy_q  <= 1'b0;
        end else if (ctl_i.clr) begin
            acc_q <= opnd_i;
            cy_q  <= 1'b0;
        end else begin
            acc_q <= total[W-1:0];
            cy_q  <= total[W];
        end
    end

    assign sum_o   = acc_q;
    assign carry_o = cy_q;

endmodule

// File: rtl/csum_status.sv
module csum_status
    import csum_pkg::*;
#(
    parameter int W    = CSUM_W,
    parameter bit PIPE = 1'b1
) (
    input  csum_ctl_t    ctl_i,
    input  logic         carry_i,
    input  logic [W-1:0] sum_i,
    output logic [W-1:0] chk_o,
    output logic         done_o,
    output logic         pass_o
);

    logic pending;

    generate
        if (PIPE) begin : g_pend
            // A clear or word still sitting in the input register.
            assign pending = ctl_i.clr | ctl_i.en;
        end else begin : g_nopend
            assign pending = 1'b0;
        end
    endgenerate

    assign chk_o  = ~sum_i;
    assign done_o = ~carry_i & ~pending;
    assign pass_o = done_o & ((&sum_i) | ~(|sum_i));

endmodule

// File: rtl/csum_engine.sv
module csum_engine
    import csum_pkg::*;
#(
    parameter int W    = CSUM_W,
    parameter bit PIPE = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] chk_o,
    output logic         done_o,
    output logic         pass_o
);

    csum_ctl_t    stg_ctl;
    logic [W-1:0] stg_opnd;
    logic         carry_q;

    csum_in_stage #(.W(W), .PIPE(PIPE)) u_stage (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (clr_i),
        .en_i   (en_i),
        .data_i (data_i),
        .ctl_o  (stg_ctl),
        .opnd_o (stg_opnd)
    );

    csum_accum #(.W(W)) u_accum (
        .clk     (clk),
        .rst     (rst),
        .ctl_i   (stg_ctl),
        .opnd_i  (stg_opnd),
        .sum_o   (sum_o),
        .carry_o (carry_q)
    );

    csum_status #(.W(W), .PIPE(PIPE)) u_status (
        .ctl_i   (stg_ctl),
        .carry_i (carry_q),
        .sum_i   (sum_o),
        .chk_o   (chk_o),
        .done_o  (done_o),
        .pass_o  (pass_o)
    );

endmodule

// File: rtl/csum_engine_chk.sv
module csum_engine_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         stg_clr,
    input logic         stg_en,
    input logic [W-1:0] stg_opnd,
    input logic         carry_q,
    input logic [W-1:0] sum_o,
    input logic         done_o,
    input logic         pass_o
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // R1: a clear at the adder stage loads the operand and drops the carry
    assert_clear_load_R1: assert property (@(posedge clk) disable iff (rst)
        stg_clr |=> (sum_o == $past(stg_opnd)) && !carry_q);

    // R2: an idle cycle with a stored carry adds exactly one
    assert_carry_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (!stg_clr && !stg_en && carry_q) |=> (sum_o == $past(sum_o) + ONE));

    // R3: idle with no carry leaves the sum untouched
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!stg_clr && !stg_en && !carry_q) |=> $stable(sum_o));

    // R4: a pending carry keeps done low
    assert_carry_not_done_R4: assert property (@(posedge clk) disable iff (rst)
        carry_q |-> !done_o);

    // R6: pass only on a settled all-zeros or all-ones sum
    assert_pass_settled_R6: assert property (@(posedge clk) disable iff (rst)
        pass_o |-> (done_o && ((sum_o == '0) || (sum_o == '1))));

endmodule

bind csum_engine csum_engine_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .stg_clr  (stg_ctl.clr),
    .stg_en   (stg_ctl.en),
    .stg_opnd (stg_opnd),
    .carry_q  (carry_q),
    .sum_o    (sum_o),
    .done_o   (done_o),
    .pass_o   (pass_o)
);

// File: tb/csum_engine_tb.sv
`timescale 1ns/1ps
module csum_engine_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 1'b0;
    logic        en  = 1'b0;
    logic [15:0] data = '0;

    logic [15:0] sum, chk, sum_p, chk_p;
    logic [3:0]  sum_n, chk_n;
    logic        done, pass, done_p, pass_p, done_n, pass_n;

    int checks = 0;
    int errors = 0;

    logic [15:0] fr [0:39];
    int          flen;

    always #2.5 clk = ~clk;

    csum_engine #(.W(16), .PIPE(1'b0)) u_dut (
        .clk(clk), .rst(rst), .clr_i(clr), .en_i(en), .data_i(data),
        .sum_o(sum), .chk_o(chk), .done_o(done), .pass_o(pass));

    csum_engine #(.W(16), .PIPE(1'b1)) u_dut_p (
        .clk(clk), .rst(rst), .clr_i(clr), .en_i(en), .data_i(data),
        .sum_o(sum_p), .chk_o(chk_p), .done_o(done_p), .pass_o(pass_p));

    csum_engine #(.W(4), .PIPE(1'b0)) u_dut_n (
        .clk(clk), .rst(rst), .clr_i(clr), .en_i(en), .data_i(data[3:0]),
        .sum_o(sum_n), .chk_o(chk_n), .done_o(done_n), .pass_o(pass_n));

    function automatic int unsigned fold(int unsigned s, int w);
        int unsigned m = (32'd1 << w) - 1;
        while (s > m) s = (s & m) + (s >> w);
        return s;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(bit c, bit e, logic [15:0] d);
        @(negedge clk);
        clr  = c;
        en   = e;
        data = d;
    endtask

    // Send fr[0..flen-1], idle cycles inserted with the given percentage.
    task automatic send_frame(int gap_pct);
        for (int i = 0; i < flen; i++) begin
            if (i > 0 && ($urandom % 100) < gap_pct)
                drive(1'b0, 1'b0, 16'($urandom));
            drive(i == 0, 1'b1, fr[i]);
        end
        drive(1'b0, 1'b0, 16'($urandom));
        for (int k = 0; k < 8; k++) begin
            if (done && done_p && done_n) break;
            @(negedge clk);
        end
    endtask

    task automatic check_frame(output int unsigned f16o);
        int unsigned s16 = 0;
        int unsigned s4 = 0;
        int unsigned f16, f4;
        for (int i = 0; i < flen; i++) begin
            s16 += fr[i];
            s4  += fr[i][3:0];
        end
        f16 = fold(s16, 16);
        f4  = fold(s4, 4);
        f16o = f16;
        check(done && done_p && done_n, "R4", {done, done_p, done_n}, 3'b111);
        check(sum == 16'(f16), "R2", sum, f16);
        check(sum_p == 16'(f16), "R2", sum_p, f16);
        check(sum_n == 4'(f4), "R2", sum_n, f4);
        check(chk == ~16'(f16), "R5", chk, ~16'(f16));
        check(chk_n == ~4'(f4), "R5", chk_n, ~4'(f4));
        check(pass == (f16 == 0 || f16 == 16'hFFFF), "R6", pass,
              (f16 == 0 || f16 == 16'hFFFF));
        check(pass_p == pass, "R6", pass_p, pass);
        check(pass_n == (f4 == 0 || f4 == 4'hF), "R6", pass_n,
              (f4 == 0 || f4 == 4'hF));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned f;
        logic [15:0] prev, w0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8: reset state
        check(sum == 16'h0 && sum_p == 16'h0, "R8", sum, 0);
        check(chk == 16'hFFFF, "R8", chk, 16'hFFFF);
        check(done && done_p && pass && pass_p, "R8",
              {done, done_p, pass, pass_p}, 4'hF);

        // R5: worked example
        flen = 1; fr[0] = 16'h8DC8;
        send_frame(0);
        check_frame(f);
        check(chk == 16'h7237, "R5", chk, 16'h7237);

        // R4, R2: end-around carry after two all-ones words
        drive(1'b1, 1'b1, 16'hFFFF);
        drive(1'b0, 1'b1, 16'hFFFF);
        drive(1'b0, 1'b0, 16'h1234);
        check(sum == 16'hFFFE && !done, "R4", {done, sum}, 17'h0FFFE);
        @(negedge clk);
        check(sum == 16'hFFFF && done, "R2", {done, sum}, 17'h1FFFF);
        check(sum_p == 16'hFFFE && !done_p, "R4", {done_p, sum_p}, 17'h0FFFE);
        check(pass, "R6", pass, 1);
        // R3: idle cycles with random data change nothing
        for (int k = 0; k < 3; k++) drive(1'b0, 1'b0, 16'($urandom));
        check(sum == 16'hFFFF && sum_p == 16'hFFFF, "R3", sum_p, 16'hFFFF);

        // R7: latency of the input register
        prev = sum_p;
        w0 = (prev == 16'h1234) ? 16'h4321 : 16'h1234;
        drive(1'b1, 1'b1, w0);
        drive(1'b0, 1'b0, 16'h0);
        check(sum == w0, "R7", sum, w0);
        check(sum_p == prev, "R7", sum_p, prev);
        @(negedge clk);
        check(sum_p == w0, "R7", sum_p, w0);

        // R1: clear with enable low empties the sum, data ignored
        drive(1'b1, 1'b0, 16'hFFFF);
        drive(1'b0, 1'b0, 16'hFFFF);
        check(sum == 16'h0 && sum_n == 4'h0, "R1", sum, 0);
        check(sum_p == w0, "R7", sum_p, w0);
        @(negedge clk);
        check(sum_p == 16'h0, "R1", sum_p, 0);

        // Random frames with gaps, their verify frames and corrupted copies
        for (int t = 0; t < 60; t++) begin
            flen = 1 + ($urandom % 32);
            for (int i = 0; i < flen; i++) fr[i] = 16'($urandom);
            send_frame(30);
            check_frame(f);
            fr[flen] = ~16'(f);
            flen++;
            send_frame(30);
            check_frame(f);
            check(pass && pass_p, "R9", {pass, pass_p}, 2'b11);
            fr[0] = fr[0] ^ (16'h1 << ($urandom % 16));
            send_frame(0);
            check_frame(f);
            check(!pass && !pass_p, "R6", {pass, pass_p}, 2'b00);
        end

        // Exhaustive sweep of two-word frames on the 4-bit engine
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                flen = 2;
                fr[0] = {12'($urandom), 4'(a)};
                fr[1] = {12'($urandom), 4'(b)};
                send_frame(0);
                check_frame(f);
                fr[2] = {12'($urandom), ~4'(fold(a + b, 4))};
                flen = 3;
                send_frame(0);
                check_frame(f);
                check(pass_n, "R9", pass_n, 1);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule